// File: doc/BRIEF.md
# Parallel disk bus PIO register-cycle host sequencer

This block runs one programmed-I/O register access at a time on a parallel ATA disk bus, from the host side. A local requester presents a read or write flag, a 5-bit register address, 16-bit write data and a PIO mode number. The block then drives the two active-low chip selects, the three device address lines and the active-low read or write strobe through four phases: address setup, strobe asserted, address hold and recovery. Every phase is timed in clock cycles, and the counts are derived from nanosecond limits and a clock-period parameter.

The device can slow a cycle down by pulling IORDY low. IORDY passes through a two-flop synchronizer, and while the synchronized value is low during the strobe phase the strobe stays asserted and the strobe-length count is frozen. A read samples the 16-bit bus on the last clock of the strobe phase. A write presents the data, with an output-enable for the pads outside the block, from the start of setup to the end of hold. The requester sees a busy level and a one-cycle completion pulse.

Top module: `pio_host_seq`

## Requirements
- R1: After reset, and whenever no access is running, both strobes and both chip selects are high, the address lines are 0, busy, done and the data output-enable are 0.
- R2: Register address bit 4 set drives cs1_n low, bit 3 set drives cs0_n low, and bits 2:0 appear on da. These values stay unchanged from the first setup cycle to the last hold cycle, and after that the chip selects go high and da goes to 0.
- R3: The setup phase (busy high, strobe still high) lasts ceil(T1/P) cycles, where P is the clock period and T1 is 70, 50, 30, 30 or 25 ns for modes 0 to 4.
- R4: With IORDY high, the strobe stays low for ceil(T2/P) cycles, where T2 is 290 ns in modes 0 to 2, 80 ns in mode 3 and 70 ns in mode 4.
- R5: After the strobe rises, the address and chip selects are held for ceil(max(T9,T4)/P) cycles, with T9 = 20/15/10/10/10 ns and T4 = 30/20/15/10/10 ns.
- R6: The recovery phase lasts at least one cycle. Busy stays high for at least ceil(T0/P) cycles in total (T0 = 600/383/330/180/120 ns). In modes 3 and 4, the strobe also stays high for at least ceil(T2i/P) cycles from its rise to the end of busy (T2i = 70 and 25 ns).
- R7: done is high for exactly one cycle, in the first cycle after busy falls, and a request presented in that cycle is accepted.
- R8: A read pulses only dior_n, and rdata takes the value of dd_in from the last clock cycle in which dior_n is low.
- R9: A write pulses only diow_n. dd_oe is high and dd_out equals the write data from the first setup cycle to the last hold cycle, and dd_oe is low otherwise. dd_oe is never high while dior_n is low.
- R10: Each cycle in which the synchronized IORDY is low during the strobe phase adds one cycle to the strobe-low time.
- R11: A request presented while busy is high is ignored. The running access keeps its address and its strobe, and no access follows it.
- R12: Mode codes 5 to 7 use the mode 0 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS ns |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an access (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register address {cs1 select, cs0 select, da} |
| req_wdata | input | DATA_W | Write data |
| req_mode | input | 3 | PIO mode number |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| cs0_n | output | 1 | Chip select 0, active low |
| cs1_n | output | 1 | Chip select 1, active low |
| da | output | 3 | Device address lines |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | DATA_W | Data to the bus pads |
| dd_oe | output | 1 | Enable for the pad drivers |
| dd_in | input | DATA_W | Data from the bus pads |
| iordy | input | 1 | Device ready, asynchronous |

## Verification
The hardest case to reach is a stall in the middle of the strobe. IORDY has to fall a known number of cycles after the strobe asserts and stay low for a fixed span. The bench lowers it on the third strobe-low cycle and raises it again after K cycles, so the synchronized low window falls entirely inside the strobe phase and the expected strobe length is exactly the base count plus K. The read-sampling instant is checked in a similar way: dd_in changes on every strobe-low cycle, so the captured value shows which clock sampled it.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;

    localparam int CNT_W     = 12;
    localparam int NUM_MODES = 5;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_HOLD,
        PH_RECOVER
    } phase_e;

    // Cycle counts for one mode
    typedef struct packed {
        cnt_t t_set;   // address setup before strobe
        cnt_t t_act;   // strobe asserted
        cnt_t t_hold;  // address / data hold after strobe
        cnt_t t_cyc;   // minimum full cycle
        cnt_t t_neg;   // minimum strobe-negated time, 0 = none
    } pio_timing_t;

    function automatic cnt_t ns_to_cyc(input int ns, input int per);
        int c;
        if (ns <= 0) return '0;
        c = (ns + per - 1) / per;
        if (c < 1) c = 1;
        return cnt_t'(c);
    endfunction

    function automatic int setup_ns(input int m);
        case (m)
            0: return 70;
            1: return 50;
            2: return 30;
            3: return 30;
            default: return 25;
        endcase
    endfunction

    function automatic int active_ns(input int m);
        case (m)
            3: return 80;
            4: return 70;
            default: return 290;
        endcase
    endfunction

    function automatic int hold_ns(input int m);
        // larger of address hold and write-data hold
        case (m)
            0: return 30;
            1: return 20;
            2: return 15;
            default: return 10;
        endcase
    endfunction

    function automatic int cycle_ns(input int m);
        case (m)
            0: return 600;
            1: return 383;
            2: return 330;
            3: return 180;
            default: return 120;
        endcase
    endfunction

    function automatic int negated_ns(input int m);
        case (m)
            3: return 70;
            4: return 25;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pio_iordy_sync.sv
`timescale 1ns/1ps
module pio_iordy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pio_mode_timing.sv
`timescale 1ns/1ps
module pio_mode_timing
    import pio_pkg::*;
#(
    parameter int CLK_NS = 4,
    parameter int MODE_W = 3
) (
    input  logic [MODE_W-1:0] mode,
    output pio_timing_t       tim
);
    pio_timing_t tab [NUM_MODES];

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
        assign tab[g] = '{
            t_set:  ns_to_cyc(setup_ns(g),   CLK_NS),
            t_act:  ns_to_cyc(active_ns(g),  CLK_NS),
            t_hold: ns_to_cyc(hold_ns(g),    CLK_NS),
            t_cyc:  ns_to_cyc(cycle_ns(g),   CLK_NS),
            t_neg:  ns_to_cyc(negated_ns(g), CLK_NS)
        };
    end

    always_comb begin
        tim = tab[0];
        for (int i = 1; i < NUM_MODES; i++) begin
            if (int'(mode) == i) tim = tab[i];
        end
    end
endmodule

// File: rtl/pio_host_seq.sv
`timescale 1ns/1ps
module pio_host_seq
    import pio_pkg::*;
#(
    parameter int CLK_NS  = 4,
    parameter int DATA_W  = 16,
    parameter int DA_W    = 3,
    parameter int MODE_W  = 3,
    parameter int SYNC_ST = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [DA_W+1:0]      req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [MODE_W-1:0]    req_mode,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic                 cs0_n,
    output logic                 cs1_n,
    output logic [DA_W-1:0]      da,
    output logic                 dior_n,
    output logic                 diow_n,
    output logic [DATA_W-1:0]    dd_out,
    output logic                 dd_oe,
    input  logic [DATA_W-1:0]    dd_in,
    input  logic                 iordy
);
    localparam int ADDR_W = DA_W + 2;

    typedef struct packed {
        phase_e              ph;
        logic                wr;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        pio_timing_t         tim;
        cnt_t                cnt;
        cnt_t                tot;
        cnt_t                neg;
        logic [DATA_W-1:0]   rdata;
        logic                done;
        logic                rd_n;
        logic                wr_n;
        logic                cs0_n;
        logic                cs1_n;
        logic [DA_W-1:0]     da;
        logic                oe;
    } seq_t;

    seq_t        st_d, st_q;
    pio_timing_t mode_tim;
    logic        rdy_s;
    logic        drive_addr;

    pio_mode_timing #(.CLK_NS(CLK_NS), .MODE_W(MODE_W)) u_tim (
        .mode (req_mode),
        .tim  (mode_tim)
    );

    pio_iordy_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (iordy),
        .q     (rdy_s)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.ph != PH_IDLE && st_q.tot != '1) st_d.tot = st_q.tot + cnt_t'(1);
        if ((st_q.ph == PH_HOLD || st_q.ph == PH_RECOVER) && st_q.neg != '1)
            st_d.neg = st_q.neg + cnt_t'(1);

        case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.ph    = PH_SETUP;
                    st_d.wr    = req_write;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.tim   = mode_tim;
                    st_d.cnt   = mode_tim.t_set - cnt_t'(1);
                    st_d.tot   = '0;
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_ACTIVE;
                    st_d.cnt = st_q.tim.t_act - cnt_t'(1);
                end else begin
                    st_d.cnt = st_q.cnt - cnt_t'(1);
                end
            end
            PH_ACTIVE: begin
                if (rdy_s) begin
                    if (st_q.cnt == '0) begin
                        st_d.ph  = PH_HOLD;
                        st_d.cnt = st_q.tim.t_hold - cnt_t'(1);
                        st_d.neg = '0;
                        if (!st_q.wr) st_d.rdata = dd_in;
                    end else begin
                        st_d.cnt = st_q.cnt - cnt_t'(1);
                    end
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == '0) st_d.ph  = PH_RECOVER;
                else                st_d.cnt = st_q.cnt - cnt_t'(1);
            end
            PH_RECOVER: begin
                if (({1'b0, st_q.tot} + 1'b1) >= {1'b0, st_q.tim.t_cyc} &&
                    ({1'b0, st_q.neg} + 1'b1) >= {1'b0, st_q.tim.t_neg}) begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase

        // registered pin values follow the next phase
        drive_addr = (st_d.ph == PH_SETUP) || (st_d.ph == PH_ACTIVE) ||
                     (st_d.ph == PH_HOLD);
        st_d.rd_n  = !(st_d.ph == PH_ACTIVE && !st_d.wr);
        st_d.wr_n  = !(st_d.ph == PH_ACTIVE &&  st_d.wr);
        st_d.cs1_n = drive_addr ? !st_d.addr[ADDR_W-1] : 1'b1;
        st_d.cs0_n = drive_addr ? !st_d.addr[ADDR_W-2] : 1'b1;
        st_d.da    = drive_addr ? st_d.addr[DA_W-1:0]  : '0;
        st_d.oe    = drive_addr && st_d.wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.rd_n  <= 1'b1;
            st_q.wr_n  <= 1'b1;
            st_q.cs0_n <= 1'b1;
            st_q.cs1_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = (st_q.ph != PH_IDLE);
    assign done   = st_q.done;
    assign rdata  = st_q.rdata;
    assign cs0_n  = st_q.cs0_n;
    assign cs1_n  = st_q.cs1_n;
    assign da     = st_q.da;
    assign dior_n = st_q.rd_n;
    assign diow_n = st_q.wr_n;
    assign dd_out = st_q.wdata;
    assign dd_oe  = st_q.oe;

    // R9
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));

    // R2
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(dior_n && diow_n)) |-> $stable({cs1_n, cs0_n, da}));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    iordy_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_ACTIVE && !rdy_s) |=> (st_q.ph == PH_ACTIVE));

    // R9
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dior_n |-> !dd_oe);

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dior_n && diow_n && cs0_n && cs1_n && !dd_oe));
endmodule

// File: tb/sim_pio_host_seq.sv
`timescale 1ns/1ps
module sim_pio_host_seq;

    typedef struct packed {
        logic        wr;
        logic [4:0]  addr;
        logic [15:0] data;
        logic [2:0]  mode;
        logic [7:0]  stall;
        logic [7:0]  e_set;
        logic [7:0]  e_low;
        logic [7:0]  e_hold;
        logic [7:0]  e_tot;
    } vec_t;

    // Expected counts at a 4 ns clock
    localparam vec_t VECS [8] = '{
        '{1'b0, 5'b01010, 16'h1200, 3'd0, 8'd0,  8'd18, 8'd73, 8'd8, 8'd150},
        '{1'b1, 5'b10110, 16'hA5C3, 3'd1, 8'd0,  8'd13, 8'd73, 8'd5, 8'd96},
        '{1'b0, 5'b01111, 16'h3400, 3'd2, 8'd0,  8'd8,  8'd73, 8'd4, 8'd86},
        '{1'b1, 5'b11001, 16'h5AA5, 3'd3, 8'd0,  8'd8,  8'd20, 8'd3, 8'd46},
        '{1'b0, 5'b01000, 16'h7000, 3'd4, 8'd0,  8'd7,  8'd18, 8'd3, 8'd32},
        '{1'b1, 5'b01101, 16'hC0DE, 3'd4, 8'd10, 8'd7,  8'd28, 8'd3, 8'd42},
        '{1'b0, 5'b10011, 16'h0800, 3'd0, 8'd20, 8'd18, 8'd93, 8'd8, 8'd150},
        '{1'b0, 5'b01100, 16'h9900, 3'd6, 8'd0,  8'd18, 8'd73, 8'd8, 8'd150}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [2:0]  req_mode = '0;
    logic [15:0] dd_in = '0;
    logic        iordy = 1'b1;
    logic        busy, done, cs0_n, cs1_n, dior_n, diow_n, dd_oe;
    logic [15:0] rdata, dd_out;
    logic [2:0]  da;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pio_host_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mode(req_mode),
        .busy(busy), .done(done), .rdata(rdata), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .da(da), .dior_n(dior_n), .diow_n(diow_n), .dd_out(dd_out),
        .dd_oe(dd_oe), .dd_in(dd_in), .iordy(iordy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_txn(input vec_t v);
        int n_set = 0, n_low = 0, n_hold = 0, n_tot = 0;
        int strobe_bad = 0, addr_bad = 0, oe_bad = 0, stall_ctr = 0;
        bit seen_low = 0, stalling = 0, cs_on, lowc, other;
        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_addr = v.addr;
        req_wdata = v.data; req_mode = v.mode; dd_in = v.data; iordy = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy && n_tot < 2000) begin
            cs_on = !(cs0_n && cs1_n);
            lowc  = v.wr ? !diow_n : !dior_n;
            other = v.wr ? !dior_n : !diow_n;
            if (other) strobe_bad++;
            if (cs_on && ({!cs1_n, !cs0_n, da} != v.addr)) addr_bad++;
            if (dd_oe != (v.wr && cs_on)) oe_bad++;
            if (dd_oe && dd_out != v.data) oe_bad++;
            if (stalling) begin
                stall_ctr++;
                if (stall_ctr == int'(v.stall)) begin iordy = 1'b1; stalling = 0; end
            end
            if (lowc) begin
                n_low++; seen_low = 1;
                dd_in = v.data + 16'(n_low);
                if (v.stall != 0 && n_low == 3) begin iordy = 1'b0; stalling = 1; stall_ctr = 0; end
            end else if (!seen_low) n_set++;
            else if (cs_on) n_hold++;
            n_tot++;
            @(negedge clk);
        end
        chk(done == 1'b1, "R7 done after busy", int'(done), 1);
        chk(n_set == int'(v.e_set), v.mode > 4 ? "R12 setup" : "R3 setup", n_set, int'(v.e_set));
        chk(n_low == int'(v.e_low), v.stall != 0 ? "R10 strobe low" : "R4 strobe low", n_low, int'(v.e_low));
        chk(n_hold == int'(v.e_hold), "R5 hold", n_hold, int'(v.e_hold));
        chk(n_tot == int'(v.e_tot), v.mode > 4 ? "R12 busy length" : "R6 busy length", n_tot, int'(v.e_tot));
        chk(addr_bad == 0, "R2 address pins", addr_bad, 0);
        chk(strobe_bad == 0, v.wr ? "R9 wrong strobe" : "R8 wrong strobe", strobe_bad, 0);
        chk(oe_bad == 0, "R9 data drive", oe_bad, 0);
        if (!v.wr)
            chk(rdata == v.data + 16'(v.e_low), "R8 read capture", int'(rdata), int'(v.data + 16'(v.e_low)));
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R7 done single cycle", int'({busy, done}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(dior_n && diow_n && cs0_n && cs1_n && da == 0 && !busy && !done && !dd_oe,
            "R1 pins in reset", int'({dior_n, diow_n, cs0_n, cs1_n, busy, done, dd_oe}), 7'b1111000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(dior_n && diow_n && cs0_n && cs1_n && da == 0 && !busy && !done && !dd_oe,
            "R1 pins after reset", int'({dior_n, diow_n, cs0_n, cs1_n, busy, done, dd_oe}), 7'b1111000);

        foreach (VECS[i]) run_txn(VECS[i]);

        // R11 request during busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 5'b01000; req_mode = 3'd4;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 5'b10111; req_mode = 3'd0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk(da == 3'b000 && !cs0_n && cs1_n && diow_n && !dior_n, "R11 running access kept",
            int'({da, cs0_n, cs1_n, diow_n, dior_n}), 7'b0000110);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(!busy && diow_n, "R11 no follow-on access", int'(busy), 0);

        // R7 request in the done cycle is accepted
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 5'b01001; req_mode = 3'd4;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_addr = 5'b01110;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && da == 3'b110, "R7 back-to-back accept", int'({busy, da}), 4'b1110);
        while (busy) @(negedge clk);
        @(negedge clk);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule